// File: doc/BRIEF.md
# Asynchronous Memory Cycle Sequencer

This block turns single-word requests from an internal request/acknowledge port into read or write cycles on an external asynchronous memory or peripheral bus. Every cycle runs three phases in a fixed order: an address setup phase, a strobe phase and a hold phase. Chip select and address are valid in all three. The read or write strobe is active only in the strobe phase. Each phase lasts a whole number of interface clocks.

Every chip select owns a timing word with six counts, a setup, strobe and hold length for reads and another such triple for writes. Software writes these words through a small configuration port. The timing of the selected chip select is latched when a request is accepted. An external ready input passes through a synchronizer and can stretch the strobe phase. Read data is captured when the read strobe ends and returned to the requester with the acknowledge pulse.

Top module: `asmem_seq`

## Requirements
- R1: After reset, all chip selects, the output-enable, the read strobe and the write strobe are high (inactive), `mem_wdata_oe` and `req_ack` are low, and no cycle starts until a request arrives.
- R2: A pulse on `cfg_we` stores `cfg_word` as the timing of chip select `cfg_cs`. Each chip select keeps its own word. With the default 4-bit counts the fields are: read setup [23:20], read strobe [19:16], read hold [15:12], write setup [11:8], write strobe [7:4], write hold [3:0].
- R3: A count field programmed as 0 acts as a count of 1.
- R4: In a read, chip select, address and `mem_oe_n` are active for exactly read-setup cycles before `mem_re_n` falls. `mem_re_n` then stays low for the strobe length. All three stay active for exactly read-hold cycles after it rises. Address and chip select stay stable for the whole cycle.
- R5: A write follows the same sequence with the write triple and `mem_we_n`. `mem_oe_n` stays high, and `mem_wdata_oe` is high with `mem_wdata` equal to the request data for the whole cycle.
- R6: While ready stays high, the strobe lasts max(strobe count, 3) cycles. Three cycles is the latency of the two-stage ready synchronizer plus the deciding edge.
- R7: A low level on `mem_ready` in strobe cycles 0 to N-1 (N ≥ 1) stretches the strobe to max(strobe count, N+3) cycles. The strobe ends only after ready, sampled three clocks earlier, is high.
- R8: `req_rdata` holds the `mem_rdata` value sampled at the edge where `mem_re_n` goes high.
- R9: `req_ack` is high for exactly one clock, the last hold cycle. The bus is idle in the following clock, and a new request is accepted only in an idle clock.
- R10: At most one chip select is low at a time, and it is the one the request named. Read and write strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_cs | input | CS_W | Chip select whose timing is written |
| cfg_word | input | 6*PH_W | Six phase counts |
| req_valid | input | 1 | Request pending, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_W | Target chip select |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | One-clock completion pulse |
| req_rdata | output | DATA_W | Read data, valid with `req_ack` |
| mem_cs_n | output | CS_N | Active-low chip selects |
| mem_addr | output | ADDR_W | External address |
| mem_oe_n | output | 1 | Active-low output enable for reads |
| mem_re_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_wdata | output | DATA_W | External write data |
| mem_wdata_oe | output | 1 | Write data bus drive enable |
| mem_rdata | input | DATA_W | External read data |
| mem_ready | input | 1 | Asynchronous ready, low stretches the strobe |

## Verification
The assertions assume that `mem_ready` changes only between clock edges and is high in the clocks that decide the end of a strobe. They also assume that the requester holds a request steady until its acknowledge and sends only in-range chip select numbers. The stimulus drives every input at the falling edge. It raises a request only after the previous acknowledge, and it pulls ready low only for a chosen number of cycles counted from the first strobe cycle, so the stretch length it predicts follows directly from R7.

// File: rtl/asmem_pkg.sv
// Shared definitions for the asynchronous memory cycle sequencer.
package asmem_pkg;
    // Number of count fields in one chip-select timing word.
    localparam int FIELDS = 6;

    // Bus cycle phases, walked in this order.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;
endpackage

// File: rtl/asmem_rdy_sync.sv
// Ready synchronizer: a plain flop chain that brings the asynchronous
// ready pin into the interface clock domain.
// Assumes STAGES >= 2; the output lags the pin by STAGES clocks.
module asmem_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the pin level one stage further each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/asmem_cfg_bank.sv
// Timing word store: one six-field word per chip select, written from the
// configuration port and read combinationally by the request path.
// Assumes wsel and rsel are below CS_N.
module asmem_cfg_bank #(
    parameter int CS_N  = 4,
    parameter int PH_W  = 4,
    localparam int CS_W  = (CS_N > 1) ? $clog2(CS_N) : 1,
    localparam int CFG_W = asmem_pkg::FIELDS * PH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CS_W-1:0]  wsel,
    input  logic [CFG_W-1:0] wword,
    input  logic [CS_W-1:0]  rsel,
    output logic [CFG_W-1:0] rword
);
    logic [CFG_W-1:0] bank [CS_N];

    for (genvar g = 0; g < CS_N; g++) begin : g_entry
        // Load this chip select's word when the port addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)                           bank[g] <= '0;
            else if (we && wsel == CS_W'(g))      bank[g] <= wword;
        end
    end

    assign rword = bank[rsel];
endmodule

// File: rtl/asmem_phase_fsm.sv
// Phase sequencer: walks setup, strobe and hold with one down counter.
// Counts of zero are raised to one. The strobe may end only after it has
// run SYNC_STAGES cycles, so the synchronized ready reflects strobe-time
// pin levels, and only while that ready is high.
// Assumes 'start' is raised only while phase is PH_IDLE.
module asmem_phase_fsm
    import asmem_pkg::*;
#(
    parameter int PH_W        = 4,
    parameter int SYNC_STAGES = 2,
    localparam int AGE_W      = $clog2(SYNC_STAGES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [PH_W-1:0] t_setup,
    input  logic [PH_W-1:0] t_strobe,
    input  logic [PH_W-1:0] t_hold,
    input  logic            rdy_s,
    output phase_e          phase,
    output logic            strobe_end,
    output logic            last_hold
);
    localparam logic [PH_W-1:0]  ONE      = PH_W'(1);
    localparam logic [AGE_W-1:0] AGE_FULL = AGE_W'(SYNC_STAGES);

    logic [PH_W-1:0]  cnt;
    logic [PH_W-1:0]  strobe_len;
    logic [PH_W-1:0]  hold_len;
    logic [AGE_W-1:0] age;

    function automatic logic [PH_W-1:0] at_least_one(input logic [PH_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    assign strobe_end = (phase == PH_STROBE) && (cnt == ONE) && (age == AGE_FULL) && rdy_s;
    assign last_hold  = (phase == PH_HOLD) && (cnt == ONE);

    // Advance the phase and its counter once per interface clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            strobe_len <= '0;
            hold_len   <= '0;
            age        <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase      <= PH_SETUP;
                    cnt        <= at_least_one(t_setup);
                    strobe_len <= at_least_one(t_strobe);
                    hold_len   <= at_least_one(t_hold);
                end
                PH_SETUP: if (cnt == ONE) begin
                    phase <= PH_STROBE;
                    cnt   <= strobe_len;
                    age   <= '0;
                end else begin
                    cnt <= cnt - ONE;
                end
                PH_STROBE: if (strobe_end) begin
                    phase <= PH_HOLD;
                    cnt   <= hold_len;
                end else begin
                    if (cnt != ONE)      cnt <= cnt - ONE;
                    if (age != AGE_FULL) age <= age + AGE_W'(1);
                end
                PH_HOLD: if (cnt == ONE) begin
                    phase <= PH_IDLE;
                end else begin
                    cnt <= cnt - ONE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/asmem_seq.sv
// Asynchronous memory cycle sequencer top: accepts a request when idle,
// latches its chip select, address, data and timing triple, and drives
// the external strobes from the phase sequencer. Read data is taken at
// the edge that ends the read strobe.
// Assumes the requester holds req_* stable until req_ack.
module asmem_seq
    import asmem_pkg::*;
#(
    parameter int CS_N        = 4,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int PH_W        = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CS_W       = (CS_N > 1) ? $clog2(CS_N) : 1,
    localparam int CFG_W      = FIELDS * PH_W,
    localparam int TRIPLE_W   = 3 * PH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CS_W-1:0]   cfg_cs,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] req_rdata,
    output logic [CS_N-1:0]   mem_cs_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_oe_n,
    output logic              mem_re_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_oe,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    logic [CFG_W-1:0]    sel_word;
    logic [TRIPLE_W-1:0] triple;
    logic                rdy_s;
    phase_e              phase;
    logic                strobe_end;
    logic                last_hold;
    logic                accept;
    logic                busy;

    logic [CS_W-1:0]     cs_q;
    logic                wr_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   rdata_q;

    asmem_cfg_bank #(.CS_N(CS_N), .PH_W(PH_W)) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wsel  (cfg_cs),
        .wword (cfg_word),
        .rsel  (req_cs),
        .rword (sel_word)
    );

    asmem_rdy_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (mem_ready),
        .dout  (rdy_s)
    );

    // Read triple sits in the upper half of the word, write triple below.
    assign triple = req_write ? sel_word[TRIPLE_W-1:0] : sel_word[CFG_W-1:TRIPLE_W];
    assign accept = req_valid && (phase == PH_IDLE);

    asmem_phase_fsm #(.PH_W(PH_W), .SYNC_STAGES(SYNC_STAGES)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .t_setup    (triple[3*PH_W-1:2*PH_W]),
        .t_strobe   (triple[2*PH_W-1:PH_W]),
        .t_hold     (triple[PH_W-1:0]),
        .rdy_s      (rdy_s),
        .phase      (phase),
        .strobe_end (strobe_end),
        .last_hold  (last_hold)
    );

    // Hold the request fields for the life of the bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q    <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            cs_q    <= req_cs;
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Take read data at the edge that releases the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rdata_q <= '0;
        else if (strobe_end && !wr_q) rdata_q <= mem_rdata;
    end

    assign busy = (phase != PH_IDLE);

    for (genvar g = 0; g < CS_N; g++) begin : g_cs
        assign mem_cs_n[g] = !(busy && cs_q == CS_W'(g));
    end

    assign mem_addr     = addr_q;
    assign mem_oe_n     = !(busy && !wr_q);
    assign mem_re_n     = !((phase == PH_STROBE) && !wr_q);
    assign mem_we_n     = !((phase == PH_STROBE) && wr_q);
    assign mem_wdata    = wdata_q;
    assign mem_wdata_oe = busy && wr_q;
    assign req_ack      = last_hold;
    assign req_rdata    = rdata_q;
endmodule

// File: rtl/asmem_chk.sv
// Protocol checker for asmem_seq, attached by bind. Observes only the
// block's ports. Assumes mem_ready is high in the clocks that end a strobe.
module asmem_chk #(
    parameter int CS_N   = 4,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CS_N-1:0]   mem_cs_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_re_n,
    input logic              mem_we_n,
    input logic              mem_ready,
    input logic              req_ack
);
    // R10: never more than one chip select active.
    p_cs_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    // R10: read and write strobes never overlap.
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_re_n && !mem_we_n));

    // R4: a strobe only occurs inside an active chip select.
    p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_re_n || !mem_we_n) |-> !(&mem_cs_n));

    // R4: address and chip select stay still until the cycle completes.
    p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&mem_cs_n) && !req_ack) |=> ($stable(mem_addr) && $stable(mem_cs_n)));

    // R9: acknowledge is a single-clock pulse.
    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    // R9: the clock after acknowledge is idle on the bus.
    p_ack_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> (&mem_cs_n));

    // R6: a read strobe lasts at least three clocks.
    p_min_rd_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_re_n) |-> !$past(mem_re_n, 3));

    // R6: a write strobe lasts at least three clocks.
    p_min_wr_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !$past(mem_we_n, 3));

    // R7: a strobe ends only on ready seen three clocks before its end.
    p_ready_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_re_n) || $rose(mem_we_n)) |-> $past(mem_ready, 3));
endmodule

bind asmem_seq asmem_chk #(.CS_N(CS_N), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_cs_n  (mem_cs_n),
    .mem_addr  (mem_addr),
    .mem_re_n  (mem_re_n),
    .mem_we_n  (mem_we_n),
    .mem_ready (mem_ready),
    .req_ack   (req_ack)
);

// File: tb/asmem_seq_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task pushes the expected cycle shape into a
// queue; a monitor measures each bus cycle at the pins and compares at ack.
module asmem_seq_tb_top;
    localparam int CS_N = 4;
    localparam int AW   = 16;
    localparam int DW   = 16;
    localparam int PW   = 4;
    localparam logic [DW-1:0] RD_KEY  = 16'h5A3C;
    localparam logic [DW-1:0] RD_IDLE = 16'hDEAD;

    typedef struct {
        bit         wr;
        int         cs;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        int         ns, nl, nh;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_cs = '0;
    logic [6*PW-1:0] cfg_word = '0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_cs = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ack;
    logic [DW-1:0] req_rdata;
    logic [CS_N-1:0] mem_cs_n;
    logic [AW-1:0] mem_addr;
    logic mem_oe_n, mem_re_n, mem_we_n, mem_wdata_oe;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic mem_ready = 1'b1;

    int n_cmp = 0, n_bad = 0;
    int stall_n = 0;
    int cfg_m [CS_N][6];
    exp_t sb [$];

    always #4 clk = ~clk;

    // Memory model: data only while the read strobe is low.
    assign mem_rdata = !mem_re_n ? (mem_addr ^ RD_KEY) : RD_IDLE;

    asmem_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cs(cfg_cs), .cfg_word(cfg_word),
        .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .req_rdata(req_rdata), .mem_cs_n(mem_cs_n), .mem_addr(mem_addr),
        .mem_oe_n(mem_oe_n), .mem_re_n(mem_re_n), .mem_we_n(mem_we_n),
        .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // R2: program one chip select's six counts.
    task automatic set_cfg(input int cs, input int rs, input int rt, input int rh,
                           input int ws, input int wt, input int wh);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_cs   = 2'(cs);
        cfg_word = {PW'(rs), PW'(rt), PW'(rh), PW'(ws), PW'(wt), PW'(wh)};
        cfg_m[cs] = '{rs, rt, rh, ws, wt, wh};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: push expectation, raise the request, drop it after ack.
    task automatic issue(input bit wr, input int cs, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input int stall);
        exp_t e;
        int b;
        b = wr ? 3 : 0;
        e.wr = wr; e.cs = cs; e.addr = a; e.wdata = d;
        e.ns = eff(cfg_m[cs][b]);
        e.nl = imax(eff(cfg_m[cs][b+1]), (stall > 0) ? stall + 3 : 3);
        e.nh = eff(cfg_m[cs][b+2]);
        @(negedge clk);
        stall_n = stall;
        sb.push_back(e);
        req_valid = 1'b1; req_write = wr; req_cs = 2'(cs);
        req_addr = a; req_wdata = d;
        do @(negedge clk); while (!req_ack);
        req_valid = 1'b0;
    endtask

    // Monitor state.
    bit in_cyc = 0, after_ack = 0, bad_stab = 0, bad_dir = 0, wr_seen = 0;
    int ph = 0, ns = 0, nl = 0, nh = 0, cs_seen = 0;
    logic [AW-1:0] a_seen;

    // Monitor and ready driver, sampled between clock edges.
    always @(negedge clk) begin
        bit active, stb;
        exp_t e;
        active = !(&mem_cs_n);
        stb = !mem_re_n || !mem_we_n;
        if (rst_n) begin
            if (after_ack) begin
                chk("R9 bus idle after ack", int'(active), 0);
                after_ack = 0;
            end
            if (active && !in_cyc) begin
                in_cyc = 1; ph = 0; ns = 0; nl = 0; nh = 0;
                bad_stab = 0; bad_dir = 0;
                a_seen = mem_addr; wr_seen = mem_wdata_oe;
                cs_seen = 0;
                for (int i = 0; i < CS_N; i++) if (!mem_cs_n[i]) cs_seen = i;
            end
            if (in_cyc) begin
                if (mem_addr != a_seen || mem_cs_n[cs_seen]) bad_stab = 1;
                if (wr_seen) begin
                    if (!mem_oe_n || !mem_wdata_oe || !mem_re_n) bad_dir = 1;
                end else begin
                    if (mem_oe_n || mem_wdata_oe || !mem_we_n) bad_dir = 1;
                end
                if (stb) begin
                    ph = 1;
                    mem_ready = (nl >= stall_n);
                    nl++;
                end else begin
                    mem_ready = 1'b1;
                    if (ph == 0) ns++;
                    else nh++;
                end
                if (req_ack) begin
                    if (sb.size() == 0) begin
                        chk("R9 ack without request", 1, 0);
                    end else begin
                        e = sb.pop_front();
                        chk(wr_seen ? "R5 direction" : "R4 direction", int'(wr_seen), int'(e.wr));
                        chk("R10 chip select", cs_seen, e.cs);
                        chk("R4 address", int'(a_seen), int'(e.addr));
                        chk("R4 address/select stable", int'(bad_stab), 0);
                        chk(e.wr ? "R5 write pins" : "R4 read pins", int'(bad_dir), 0);
                        chk(e.wr ? "R5 setup cycles" : "R4 setup cycles", ns, e.ns);
                        chk(stall_n > 0 ? "R7 stretched strobe" : "R6 strobe cycles", nl, e.nl);
                        chk(e.wr ? "R5 hold cycles" : "R4 hold cycles", nh, e.nh);
                        if (e.wr) chk("R5 write data", int'(mem_wdata), int'(e.wdata));
                        else      chk("R8 read data", int'(req_rdata), int'(e.addr ^ RD_KEY));
                    end
                    in_cyc = 0;
                    after_ack = 1;
                end
            end else if (req_ack) begin
                chk("R9 ack outside cycle", 1, 0);
            end
        end
    end

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < CS_N; i++) cfg_m[i] = '{0, 0, 0, 0, 0, 0};
        repeat (3) @(negedge clk);
        // R1: reset values.
        chk("R1 chip selects idle", int'(mem_cs_n), 'hF);
        chk("R1 strobes idle", int'({mem_oe_n, mem_re_n, mem_we_n}), 7);
        chk("R1 ack/drive low", int'({req_ack, mem_wdata_oe}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 no cycle without request", int'(mem_cs_n), 'hF);

        // R2: distinct words per chip select; R3: chip select 1 all zero.
        set_cfg(0, 2, 4, 1, 1, 2, 3);
        set_cfg(1, 0, 0, 0, 0, 0, 0);
        set_cfg(2, 3, 1, 2, 5, 6, 1);
        set_cfg(3, 1, 7, 2, 2, 3, 2);

        issue(0, 0, 16'h1234, 16'h0000, 0);   // R4, R6 (strobe 4)
        issue(1, 0, 16'h0042, 16'hBEEF, 0);   // R5, R6 (strobe 2 -> 3)
        issue(0, 1, 16'hFFFF, 16'h0000, 0);   // R3
        issue(1, 1, 16'h8001, 16'hC0DE, 0);   // R3
        issue(0, 2, 16'h0F0F, 16'h0000, 4);   // R7: 1 vs 4+3
        issue(1, 2, 16'h7777, 16'h1357, 0);   // R5, R6 (strobe 6)
        issue(0, 3, 16'hA5A5, 16'h0000, 1);   // R7: early not-ready, 7 vs 4
        issue(0, 3, 16'h5555, 16'h0000, 6);   // R7: 7 vs 9
        issue(1, 3, 16'h2468, 16'hAAAA, 2);   // R7: 3 vs 5
        issue(0, 0, 16'h0001, 16'h0000, 0);   // R2: chip select 0 word kept
        repeat (4) @(negedge clk);
        chk("R9 every request acknowledged", sb.size(), 0);
        summary();
        $finish;
    end
endmodule